// File: doc/BRIEF.md
# Two-Wire Sensor Slave with Broadcast Slots

This block is the serial front end of a small sensor. It sits on a two-wire bus as a slave and serves a four-entry, byte-wide register file that lives outside it. SCL and SDA arrive already filtered but not yet on the core clock. The block brings them into its clock domain, finds START, STOP and the clock edges, and pulls SDA low through an open-drain enable. It never drives SCL.

The block answers to its own address, whose low three bits come from a strap index. It also answers to two broadcast address bytes. The broadcast write byte carries either a shared pointer write or a general-call reset. With the broadcast read byte, up to eight sensors share one read. Each sensor drives only the data byte whose position matches its strap index, and it stays silent once the master refuses a byte. A pointer register selects which entry is read or written, and it keeps its value across transactions. A counter watches for SCL being held low too long and returns the interface to idle.

The register file is expected to present `reg_rd_data` combinationally for the entry on `reg_addr`. It restores its own power-up contents when `gc_reset` pulses.

Top module: `i2c_bcast_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'b1110_000 OR strap_idx, with either value of the R/W bit (bit 0, 1 = read). An address byte that matches none of its addresses is not acknowledged, and the block stays silent until the next START.
- R2: The block acknowledges the broadcast write byte 8'h00 and the broadcast read byte 8'h01, whatever its strap index.
- R3: In a write to its own address, the first data byte loads the pointer from its two LSBs and is acknowledged. The second data byte gives a one-cycle reg_wr_en with that byte on reg_wr_data, and is acknowledged. Any later bytes are acknowledged and write nothing.
- R4: The pointer (reg_addr) resets to 0 and changes only on a pointer-loading byte or a general-call reset. A read to the block's own address returns the entry the pointer selects, MSB first, across any number of transactions.
- R5: After the broadcast read byte, the device whose strap index is k drives data byte k, counting from 0, with the selected entry. In every other byte slot it leaves SDA released (so those bytes read 8'hFF).
- R6: In a broadcast read, if the master does not acknowledge a byte, the device drives no later slot, including its own.
- R7: After 8'h00, a second byte of 8'h06 is acknowledged, gives a one-cycle gc_reset and returns the pointer to 0, with no write strobe.
- R8: After 8'h00, a second byte with bits 7:2 zero loads the pointer, and a third byte is written as in R3. Any other second byte except 8'h06 is acknowledged, and it and all later bytes up to the next START or STOP cause no write and no pointer change.
- R9: A first byte of the form 8'b0000_1xxx is not acknowledged. The block then ignores the bus until a repeated START.
- R10: If SCL stays low for TIMEOUT_CYCLES clock cycles, the block releases SDA and ignores the bus until the next START.
- R11: A START or STOP at any point ends the current transfer. A STOP in the middle of a data byte writes nothing.
- R12: After reset SDA is released. SDA is sampled on a detected SCL rising edge, and sda_oe changes only in the cycle after a detected SCL falling edge, START, STOP or timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered bus clock line, asynchronous |
| sda_i | input | 1 | Filtered bus data line, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_idx | input | IDX_W (3) | Static strap index: address LSBs and broadcast slot |
| reg_addr | output | PTR_W (2) | Current pointer, selects the register-file entry |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_en | output | 1 | One-cycle strobe when an entry is loaded for transmission |
| reg_rd_data | input | 8 | Entry selected by reg_addr, combinational |
| gc_reset | output | 1 | One-cycle general-call reset to the register file |

## Verification
A wrong pointer shows up at the very next read: the byte that comes out is the wrong entry, and reg_addr on the port differs at once. A slot counter that is off by one, or that keeps running after a refusal, puts data into a neighbour's byte of the broadcast read, so a sweep over every strap index checks every slot position. A decode fault in the acknowledge logic shows in the ninth clock of the same byte. A stuck timeout or abort path leaves SDA held low, or leaves the device answering bytes that were sent without a START.

// File: rtl/i2c_bcast_pkg.sv
package i2c_bcast_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] BCAST_WR_BYTE = 8'h00;
    localparam logic [BYTE_W-1:0] BCAST_RD_BYTE = 8'h01;
    localparam logic [BYTE_W-1:0] GC_RESET_CMD  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    typedef enum logic [2:0] {
        MD_NONE,
        MD_OWN_WR,
        MD_OWN_RD,
        MD_BC_WR,
        MD_BC_RD,
        MD_IGNORE
    } xfer_mode_e;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [1:0] scl_sy;
        logic [1:0] sda_sy;
        logic       scl_p;
        logic       sda_p;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.scl_sy = {smp_q.scl_sy[0], scl_i};
        smp_d.sda_sy = {smp_q.sda_sy[0], sda_i};
        smp_d.scl_p  = smp_q.scl_sy[1];
        smp_d.sda_p  = smp_q.sda_sy[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign scl_s     = smp_q.scl_sy[1];
    assign sda_s     = smp_q.sda_sy[1];
    assign scl_rise  = scl_s & ~smp_q.scl_p;
    assign scl_fall  = ~scl_s & smp_q.scl_p;
    assign start_det = scl_s & smp_q.scl_p & smp_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & smp_q.scl_p & ~smp_q.sda_p & sda_s;

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int TIMEOUT_CYCLES = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic tmo
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT   = CW'(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] LAST_LO = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (scl_s) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LIMIT) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // single pulse on the cycle the low time reaches the limit
    assign tmo = ~scl_s && (tmr_q.cnt == LAST_LO);

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_bcast_pkg::*;
#(
    parameter int          PTR_W     = 2,
    parameter int          IDX_W     = 3,
    parameter logic [6:0]  ADDR_BASE = 7'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              tmo,
    input  logic [IDX_W-1:0]  strap_idx,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en,
    output logic              gc_rst
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        bus_state_e        st;
        xfer_mode_e        md;
        logic [CNT_W-1:0]  bit_cnt;
        logic [1:0]        byte_no;
        logic [BYTE_W-1:0] sh;
        logic              ack;
        logic              oe;
        logic [PTR_W-1:0]  ptr;
        logic [IDX_W-1:0]  slot;
        logic              own_slot;
        logic              mack;
        logic              wr;
        logic [BYTE_W-1:0] wdat;
        logic              gc;
        logic              rd;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [BYTE_W-1:0] rx_byte;
    logic [6:0]        own_addr;

    assign rx_byte  = {fsm_q.sh[BYTE_W-2:0], sda_s};
    assign own_addr = ADDR_BASE | 7'(strap_idx);

    // set up one transmit byte slot: drive it when it belongs to this device
    function automatic fsm_t open_slot(fsm_t s, logic [IDX_W-1:0] ns,
                                       logic [IDX_W-1:0] idx,
                                       logic [BYTE_W-1:0] rdat);
        fsm_t r;
        r          = s;
        r.st       = ST_TX;
        r.slot     = ns;
        r.bit_cnt  = '0;
        r.own_slot = (s.md == MD_OWN_RD) || (ns == idx);
        if (r.own_slot) begin
            r.sh = rdat;
            r.oe = ~rdat[BYTE_W-1];
            r.rd = 1'b1;
        end else begin
            r.oe = 1'b0;
        end
        return r;
    endfunction

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.wr = 1'b0;
        fsm_d.gc = 1'b0;
        fsm_d.rd = 1'b0;

        if (tmo) begin
            fsm_d.st = ST_IDLE;
            fsm_d.md = MD_NONE;
            fsm_d.oe = 1'b0;
        end else if (start_det) begin
            fsm_d.st      = ST_RX;
            fsm_d.md      = MD_NONE;
            fsm_d.oe      = 1'b0;
            fsm_d.bit_cnt = '0;
            fsm_d.byte_no = '0;
        end else if (stop_det) begin
            fsm_d.st = ST_IDLE;
            fsm_d.md = MD_NONE;
            fsm_d.oe = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_IDLE: begin
                    fsm_d.oe = 1'b0;
                end

                ST_RX: begin
                    if (scl_rise && fsm_q.bit_cnt != ALL_BITS) begin
                        fsm_d.sh      = rx_byte;
                        fsm_d.bit_cnt = fsm_q.bit_cnt + 1'b1;
                        if (fsm_q.bit_cnt == LAST_BIT) begin
                            fsm_d.ack = 1'b1;
                            if (fsm_q.byte_no != 2'd3) begin
                                fsm_d.byte_no = fsm_q.byte_no + 1'b1;
                            end
                            unique case (fsm_q.byte_no)
                                2'd0: begin
                                    if (rx_byte[BYTE_W-1:1] == own_addr) begin
                                        fsm_d.md = rx_byte[0] ? MD_OWN_RD : MD_OWN_WR;
                                    end else if (rx_byte == BCAST_WR_BYTE) begin
                                        fsm_d.md = MD_BC_WR;
                                    end else if (rx_byte == BCAST_RD_BYTE) begin
                                        fsm_d.md = MD_BC_RD;
                                    end else begin
                                        fsm_d.ack = 1'b0;
                                    end
                                end
                                2'd1: begin
                                    if (fsm_q.md == MD_OWN_WR) begin
                                        fsm_d.ptr = rx_byte[PTR_W-1:0];
                                    end else if (fsm_q.md == MD_BC_WR) begin
                                        if (rx_byte == GC_RESET_CMD) begin
                                            fsm_d.gc  = 1'b1;
                                            fsm_d.ptr = '0;
                                            fsm_d.md  = MD_IGNORE;
                                        end else if (rx_byte[BYTE_W-1:PTR_W] == '0) begin
                                            fsm_d.ptr = rx_byte[PTR_W-1:0];
                                        end else begin
                                            fsm_d.md = MD_IGNORE;
                                        end
                                    end
                                end
                                2'd2: begin
                                    if (fsm_q.md == MD_OWN_WR || fsm_q.md == MD_BC_WR) begin
                                        fsm_d.wr   = 1'b1;
                                        fsm_d.wdat = rx_byte;
                                    end
                                end
                                default: begin
                                end
                            endcase
                        end
                    end else if (scl_fall && fsm_q.bit_cnt == ALL_BITS) begin
                        fsm_d.bit_cnt = '0;
                        fsm_d.oe      = fsm_q.ack;
                        fsm_d.st      = fsm_q.ack ? ST_RX_ACK : ST_IDLE;
                    end
                end

                ST_RX_ACK: begin
                    if (scl_fall) begin
                        fsm_d.oe = 1'b0;
                        if (fsm_q.md == MD_OWN_RD || fsm_q.md == MD_BC_RD) begin
                            fsm_d = open_slot(fsm_d, '0, strap_idx, rd_data);
                        end else begin
                            fsm_d.st = ST_RX;
                        end
                    end
                end

                ST_TX: begin
                    if (scl_rise) begin
                        fsm_d.bit_cnt = fsm_q.bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (fsm_q.bit_cnt == ALL_BITS) begin
                            fsm_d.oe      = 1'b0;
                            fsm_d.bit_cnt = '0;
                            fsm_d.st      = ST_TX_ACK;
                        end else if (fsm_q.own_slot) begin
                            fsm_d.sh = {fsm_q.sh[BYTE_W-2:0], 1'b1};
                            fsm_d.oe = ~fsm_q.sh[BYTE_W-2];
                        end
                    end
                end

                ST_TX_ACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (!fsm_q.mack ||
                            (fsm_q.md == MD_BC_RD && fsm_q.own_slot)) begin
                            fsm_d.st = ST_IDLE;
                            fsm_d.md = MD_NONE;
                        end else if (fsm_q.md == MD_BC_RD) begin
                            fsm_d = open_slot(fsm_d, fsm_q.slot + 1'b1, strap_idx, rd_data);
                        end else begin
                            fsm_d = open_slot(fsm_d, fsm_q.slot, strap_idx, rd_data);
                        end
                    end
                end

                default: begin
                    fsm_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= ST_IDLE;
            fsm_q.md <= MD_NONE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe  = fsm_q.oe;
    assign ptr     = fsm_q.ptr;
    assign wr_en   = fsm_q.wr;
    assign wr_data = fsm_q.wdat;
    assign rd_en   = fsm_q.rd;
    assign gc_rst  = fsm_q.gc;

endmodule

// File: rtl/i2c_bcast_slave.sv
module i2c_bcast_slave
    import i2c_bcast_pkg::*;
#(
    parameter int         TIMEOUT_CYCLES = 6_000_000,
    parameter int         PTR_W          = 2,
    parameter int         IDX_W          = 3,
    parameter logic [6:0] ADDR_BASE      = 7'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [IDX_W-1:0]  strap_idx,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rd_data,
    output logic              gc_reset
);

    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;
    logic tmo;

    i2c_bus_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_scl_timer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .tmo   (tmo)
    );

    i2c_proto_fsm #(
        .PTR_W     (PTR_W),
        .IDX_W     (IDX_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tmo       (tmo),
        .strap_idx (strap_idx),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe),
        .ptr       (reg_addr),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .rd_en     (reg_rd_en),
        .gc_rst    (gc_reset)
    );

endmodule

// File: rtl/i2c_bcast_checker.sv
module i2c_bcast_checker #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_rise,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             tmo,
    input logic [PTR_W-1:0] reg_addr,
    input logic             reg_wr_en,
    input logic             gc_reset
);

    AST_OE_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |->
        ($past(scl_fall) || $past(start_det) || $past(stop_det) || $past(tmo))); // R12

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R3

    AST_PTR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != $past(reg_addr)) |-> $past(scl_rise)); // R4

    AST_GC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gc_reset && reg_wr_en)); // R7

    AST_GC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> !gc_reset); // R7

    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !sda_oe); // R10

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R11

endmodule

bind i2c_bcast_slave i2c_bcast_checker #(
    .PTR_W (PTR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .tmo       (tmo),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .gc_reset  (gc_reset)
);

// File: tb/i2c_bcast_slave_bench.sv
module i2c_bcast_slave_bench;

    localparam int         TMO  = 400;
    localparam int         H    = 8;
    localparam logic [6:0] BASE = 7'h70;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m;
    logic       sda_m;
    logic [2:0] strap;
    logic       sda_oe;
    logic [1:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic       reg_rd_en;
    logic [7:0] reg_rd_data;
    logic       gc_reset;
    logic       sda_line;

    int total = 0;
    int bad   = 0;
    int wr_cnt = 0;
    int gc_cnt = 0;

    logic [7:0] rf   [4];
    logic [7:0] expv [4];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_bcast_slave #(
        .TIMEOUT_CYCLES (TMO)
    ) u_i2c_bcast_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .strap_idx   (strap),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data),
        .gc_reset    (gc_reset)
    );

    function automatic logic [7:0] dflt(int i);
        case (i)
            0:       return 8'h1C;
            1:       return 8'h02;
            2:       return 8'h7D;
            default: return 8'hC8;
        endcase
    endfunction

    // register file the block serves
    always_ff @(posedge clk) begin
        if (!rst_n || gc_reset) begin
            for (int i = 0; i < 4; i++) rf[i] <= dflt(i);
        end else if (reg_wr_en) begin
            rf[reg_addr] <= reg_wr_data;
        end
        if (reg_wr_en) wr_cnt <= wr_cnt + 1;
        if (gc_reset)  gc_cnt <= gc_cnt + 1;
    end

    assign reg_rd_data = rf[reg_addr];

    function automatic logic [6:0] own(int k);
        return BASE | 7'(k);
    endfunction

    task automatic wt(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bit_out(logic v);
        wt(H); sda_m = v; wt(H); scl_m = 1'b1; wt(2 * H); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic v);
        wt(H); sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
        @(negedge clk) v = sda_line;
        wt(H); scl_m = 1'b0;
    endtask

    task automatic start_c;
        wt(H); sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
    endtask

    task automatic stop_c;
        wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(2 * H);
    endtask

    task automatic send_byte(logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
    endtask

    task automatic recv_byte(logic nack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            d[i] = v;
        end
        bit_out(nack);
    endtask

    task automatic own_read(string req, output logic [7:0] d);
        logic a;
        start_c;
        send_byte({own(int'(strap)), 1'b1}, a);
        chk(a == 1'b0, req, "read address ack", a, 0);
        recv_byte(1'b1, d);
        stop_c;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       a;
        int         w0;
        int         g0;
        int         p;

        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'd0;
        for (int i = 0; i < 4; i++) expv[i] = dflt(i);
        wt(10);
        @(negedge clk);
        chk(sda_oe == 1'b0, "R12", "sda released in reset", sda_oe, 0);
        chk(reg_wr_en == 1'b0 && gc_reset == 1'b0, "R12", "no strobes in reset", reg_wr_en, 0);
        chk(reg_addr == 2'd0, "R4", "pointer after reset", reg_addr, 0);
        rst_n = 1'b1;
        wt(10);

        // sweep every strap index: own write, own read, foreign address, broadcast read
        for (int k = 0; k < 8; k++) begin
            strap = 3'(k);
            p = k % 4;
            wt(4);
            w0 = wr_cnt;
            start_c;
            send_byte({own(k), 1'b0}, a);
            chk(a == 1'b0, "R1", "own write address ack", a, 0);
            send_byte(8'(p), a);
            chk(a == 1'b0, "R3", "pointer byte ack", a, 0);
            send_byte(8'h30 + 8'(k), a);
            chk(a == 1'b0, "R3", "data byte ack", a, 0);
            send_byte(8'hEE, a);
            chk(a == 1'b0, "R3", "extra byte ack", a, 0);
            stop_c;
            expv[p] = 8'h30 + 8'(k);
            chk(wr_cnt == w0 + 1, "R3", "single write strobe", wr_cnt - w0, 1);
            chk(reg_addr == 2'(p), "R4", "pointer port", reg_addr, p);

            own_read("R4", d);
            chk(d == expv[p], "R4", "own read data", d, expv[p]);

            start_c;
            send_byte({own((k + 1) % 8), 1'b1}, a);
            chk(a == 1'b1, "R1", "foreign address not acked", a, 1);
            stop_c;

            start_c;
            send_byte(8'h01, a);
            chk(a == 1'b0, "R2", "broadcast read byte ack", a, 0);
            for (int j = 0; j < 8; j++) begin
                recv_byte(j == 7, d);
                chk(d == ((j == k) ? expv[p] : 8'hFF), "R5", "broadcast slot data",
                    d, (j == k) ? expv[p] : 8'hFF);
            end
            stop_c;
        end

        // broadcast write of pointer and data
        strap = 3'd6;
        w0 = wr_cnt;
        start_c;
        send_byte(8'h00, a);
        chk(a == 1'b0, "R2", "broadcast write byte ack", a, 0);
        send_byte(8'h02, a);
        chk(a == 1'b0, "R8", "broadcast pointer ack", a, 0);
        send_byte(8'hA5, a);
        chk(a == 1'b0, "R8", "broadcast data ack", a, 0);
        stop_c;
        expv[2] = 8'hA5;
        chk(wr_cnt == w0 + 1, "R8", "broadcast write strobe", wr_cnt - w0, 1);
        own_read("R8", d);
        chk(d == 8'hA5, "R8", "broadcast written data", d, 8'hA5);

        // pointer-only write, then two separate reads
        start_c;
        send_byte({own(6), 1'b0}, a);
        send_byte(8'h01, a);
        stop_c;
        chk(reg_addr == 2'd1, "R4", "pointer-only write", reg_addr, 1);
        own_read("R4", d);
        chk(d == expv[1], "R4", "first read after pointer write", d, expv[1]);
        own_read("R4", d);
        chk(d == expv[1], "R4", "pointer persists", d, expv[1]);

        // refusal in a slot before the own slot
        strap = 3'd5;
        start_c;
        send_byte(8'h01, a);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R6", "slot 0 from other device", d, 8'hFF);
        recv_byte(1'b1, d);
        chk(d == 8'hFF, "R6", "slot 1 refused", d, 8'hFF);
        for (int j = 2; j < 8; j++) begin
            recv_byte(1'b0, d);
            chk(d == 8'hFF, "R6", "no slot after refusal", d, 8'hFF);
        end
        stop_c;

        // unknown command after broadcast write byte
        w0 = wr_cnt;
        start_c;
        send_byte(8'h00, a);
        send_byte(8'h55, a);
        chk(a == 1'b0, "R8", "unknown command ack", a, 0);
        send_byte(8'h03, a);
        chk(a == 1'b0, "R8", "ignored byte ack", a, 0);
        send_byte(8'h99, a);
        stop_c;
        chk(wr_cnt == w0, "R8", "no write after unknown command", wr_cnt - w0, 0);
        chk(reg_addr == 2'd1, "R8", "pointer untouched", reg_addr, 1);

        // general-call reset
        w0 = wr_cnt;
        g0 = gc_cnt;
        start_c;
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        chk(a == 1'b0, "R7", "reset command ack", a, 0);
        stop_c;
        chk(gc_cnt == g0 + 1, "R7", "reset pulse count", gc_cnt - g0, 1);
        chk(wr_cnt == w0, "R7", "no write on reset", wr_cnt - w0, 0);
        chk(reg_addr == 2'd0, "R7", "pointer cleared", reg_addr, 0);
        for (int i = 0; i < 4; i++) expv[i] = dflt(i);
        own_read("R7", d);
        chk(d == dflt(0), "R7", "entry 0 after reset", d, dflt(0));

        // master code then repeated start
        start_c;
        send_byte(8'h0A, a);
        chk(a == 1'b1, "R9", "master code not acked", a, 1);
        send_byte({own(5), 1'b0}, a);
        chk(a == 1'b1, "R9", "silent until repeated start", a, 1);
        start_c;
        send_byte({own(5), 1'b1}, a);
        chk(a == 1'b0, "R9", "address after repeated start", a, 0);
        recv_byte(1'b1, d);
        chk(d == expv[0], "R9", "read after repeated start", d, expv[0]);
        stop_c;

        // STOP and START inside a data byte
        w0 = wr_cnt;
        start_c;
        send_byte({own(5), 1'b0}, a);
        send_byte(8'h03, a);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        stop_c;
        chk(wr_cnt == w0, "R11", "stop mid-byte writes nothing", wr_cnt - w0, 0);
        chk(sda_oe == 1'b0, "R11", "released after stop", sda_oe, 0);
        start_c;
        send_byte({own(5), 1'b0}, a);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        start_c;
        send_byte({own(5), 1'b1}, a);
        chk(a == 1'b0, "R11", "start mid-byte restarts", a, 0);
        recv_byte(1'b1, d);
        chk(d == expv[3], "R11", "read after abort", d, expv[3]);
        stop_c;
        chk(wr_cnt == w0, "R11", "start mid-byte writes nothing", wr_cnt - w0, 0);

        // SCL held low during the device's acknowledge
        start_c;
        for (int i = 7; i >= 0; i--) bit_out(BASE[i % 7 == i ? 0 : 0]);
        stop_c;
        start_c;
        begin
            logic [7:0] ab;
            ab = {own(5), 1'b0};
            for (int i = 7; i >= 0; i--) bit_out(ab[i]);
        end
        wt(H);
        @(negedge clk);
        chk(sda_oe == 1'b1, "R1", "ack driven before timeout", sda_oe, 1);
        wt(TMO + 20);
        @(negedge clk);
        chk(sda_oe == 1'b0, "R10", "released after timeout", sda_oe, 0);
        bit_in(a);
        send_byte({own(5), 1'b0}, a);
        chk(a == 1'b1, "R10", "ignores bus until start", a, 1);
        stop_c;
        own_read("R10", d);
        chk(d == expv[3], "R10", "normal after timeout", d, expv[3]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule